// File: doc/BRIEF.md
# Read/Write Address Signature Collector

This unit sits beside one processor core and summarizes the memory footprint of the code that core runs. Every retired load or store address is hashed into a Bloom-filter signature. Loads go into a read signature and stores go into a write signature. Each signature is split into equal sub-filters. Every sub-filter has its own fixed XOR-matrix hash, so one access sets exactly one bit in each sub-filter. Two signatures can be intersected with a bitwise AND. An empty result proves the two footprints are disjoint. A non-empty result flags a possible conflict, which may be a false positive but is never a false negative.

The unit counts retired instructions in fixed-length blocks. A block ends when the count reaches its limit, or earlier when software signals that a synchronization point was reached. At the end of a block the unit presents the current epoch timestamp and both signatures on a dump port with a valid/ready handshake. In the same cycle it clears its signatures. A sync point also loads a new timestamp from an input. Collection is switched on and off by commands. A combinational helper compares the live signatures against a pair of peer signatures and reports whether they conflict, and separately whether both live signatures are empty.

Top module: `addr_sig_collector`

## Requirements
- R1: After reset, both signatures are all-zero, collection is disabled, the instruction counter is zero, dump_valid is low and the timestamp is zero.
- R2: Sub-filter s occupies signature bits [s*SUB_W +: SUB_W], where SUB_W = SIG_W/NUM_SUB and IDX_W = log2(SUB_W). Index bit b of sub-filter s is the XOR-reduction of (address AND mask), where mask is the low ADDR_W bits of (32'h9E3779B1 * (k+1)) ^ (32'h85EBCA6B >> (k mod 32)), with k = s*IDX_W + b and the product taken modulo 2^32. A collected access sets bit s*SUB_W + index in every sub-filter.
- R3: A collected load (ret_is_mem=1, ret_is_store=0) sets bits only in the read signature. A collected store (ret_is_mem=1, ret_is_store=1) sets bits only in the write signature. A non-memory instruction (ret_is_mem=0) sets no bits.
- R4: cmd_collect_on and cmd_collect_off take effect from the next cycle. If both are high in the same cycle, off wins. While collection is disabled, accesses leave both signatures unchanged but still count as instructions.
- R5: The retirement that brings the count of accepted retirements since the last dump to BLOCK_LEN causes a dump. That dump carries the current timestamp and includes the access retiring in that cycle. The timestamp is kept.
- R6: An accepted cmd_sync causes a dump that carries the timestamp held before the command and includes any access retiring in that cycle. From the next cycle the timestamp equals sync_ts.
- R7: Every dump resets the instruction counter to zero. A sync and a counter expiry in the same cycle produce a single dump.
- R8: in_ready = !dump_valid || dump_ready. While in_ready is low, ret_valid and cmd_sync are ignored. While dump_valid is high and dump_ready is low, dump_valid and all dump data stay unchanged.
- R9: conflict = |(rd & peer_wr) | |(wr & peer_wr) | |(wr & peer_rd), computed on the live signatures. sig_empty is high exactly when both live signatures are zero.
- R10: In the cycle after a dump, both live signatures are all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_is_mem | input | 1 | The retiring instruction accesses memory |
| ret_is_store | input | 1 | The access is a store (otherwise a load) |
| ret_addr | input | ADDR_W | Address of the access |
| in_ready | output | 1 | Retirements and sync commands are accepted |
| cmd_collect_on | input | 1 | Enable address collection |
| cmd_collect_off | input | 1 | Disable address collection |
| cmd_sync | input | 1 | Synchronization point reached |
| sync_ts | input | TS_W | Timestamp to adopt after a sync |
| dump_valid | output | 1 | Dump data is presented |
| dump_ready | input | 1 | Downstream takes the dump |
| dump_ts | output | TS_W | Timestamp of the dumped block |
| dump_rd_sig | output | SIG_W | Dumped read signature |
| dump_wr_sig | output | SIG_W | Dumped write signature |
| peer_rd_sig | input | SIG_W | Peer read signature for the conflict check |
| peer_wr_sig | input | SIG_W | Peer write signature for the conflict check |
| conflict | output | 1 | Live signatures intersect the peer signatures |
| sig_empty | output | 1 | Both live signatures are zero |

## Verification
The bench builds the collector with 16-bit addresses, 64-bit signatures in four 16-bit sub-filters, a block length of 6 and 8-bit timestamps. The short block puts counter expiry, including expiry in the same cycle as a sync, within a few cycles of each other. The narrow signatures make sub-filter collisions and non-empty intersections frequent, so the conflict output is exercised in both directions. Every dump word stays small enough to be compared whole against the bench's own hash model.

// File: rtl/collector_pkg.sv
// Shared constants and the hash-mask generator for the signature collector.
// Assumes address widths of at most 32 bits.
package collector_pkg;

    localparam logic [31:0] MASK_MUL = 32'h9E3779B1;
    localparam logic [31:0] MASK_MIX = 32'h85EBCA6B;

    // Returns the 32-bit XOR-selection mask for hash output bit k.
    function automatic logic [31:0] h3_mask(input int k);
        logic [31:0] prod;
        prod = MASK_MUL * 32'(k + 1);
        return prod ^ (MASK_MIX >> (k % 32));
    endfunction

endpackage

// File: rtl/h3_sig_encoder.sv
// Maps one address onto a signature-wide vector with exactly one bit set in
// each sub-filter. Each sub-filter index comes from a fixed XOR-matrix hash.
// Assumes SIG_W is NUM_SUB times a power of two and ADDR_W <= 32.
module h3_sig_encoder #(
    parameter int ADDR_W  = 32,
    parameter int SIG_W   = 2048,
    parameter int NUM_SUB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SIG_W-1:0]  bits
);
    localparam int SUB_W = SIG_W / NUM_SUB;
    localparam int IDX_W = $clog2(SUB_W);

    logic [IDX_W-1:0] idx [NUM_SUB];

    // One hash per sub-filter, one parity tree per index bit.
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        for (genvar b = 0; b < IDX_W; b++) begin : g_bit
            localparam logic [31:0] MASK = collector_pkg::h3_mask(s * IDX_W + b);
            assign idx[s][b] = ^(addr & MASK[ADDR_W-1:0]);
        end
    end

    // Expand each index into its one-hot position inside its sub-filter.
    always_comb begin
        bits = '0;
        for (int s = 0; s < NUM_SUB; s++) begin
            bits[s*SUB_W + int'(idx[s])] = 1'b1;
        end
    end
endmodule

// File: rtl/block_counter.sv
// Counts accepted retirements within a block. It flags expiry on the
// retirement that completes BLOCK_LEN and restarts from zero on clear.
// Assumes BLOCK_LEN >= 1. Clear has priority over increment.
module block_counter #(
    parameter int BLOCK_LEN = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic expire
);
    localparam int CNT_W = $clog2(BLOCK_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: this retirement is the last one of the block.
    assign expire = inc && (cnt_q == CNT_W'(BLOCK_LEN - 1));

    // Counter register: clear on a dump, otherwise count retirements.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_cnt_in_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(BLOCK_LEN));

    assert_expire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> clr);
endmodule

// File: rtl/sig_conflict_check.sv
// Intersects the live read/write signatures with a peer pair and reports a
// possible conflict. Also reports when both live signatures are empty.
// Purely combinational.
module sig_conflict_check #(
    parameter int SIG_W = 2048
) (
    input  logic [SIG_W-1:0] rd_sig,
    input  logic [SIG_W-1:0] wr_sig,
    input  logic [SIG_W-1:0] peer_rd,
    input  logic [SIG_W-1:0] peer_wr,
    output logic             conflict,
    output logic             empty
);
    // Read-write, write-write and write-read overlaps.
    always_comb begin
        conflict = (|(rd_sig & peer_wr)) | (|(wr_sig & peer_wr)) | (|(wr_sig & peer_rd));
        empty    = ~(|rd_sig) & ~(|wr_sig);
    end
endmodule

// File: rtl/addr_sig_collector.sv
// Per-core read/write address signature collector. It hashes collected
// accesses into two Bloom signatures and counts retirements in blocks.
// On block expiry or a sync point it dumps the timestamp and both signatures
// through a valid/ready port and clears the signatures. Retirement and sync
// are back-pressured while an unconsumed dump is held.
module addr_sig_collector #(
    parameter int ADDR_W    = 32,
    parameter int SIG_W     = 2048,
    parameter int NUM_SUB   = 4,
    parameter int BLOCK_LEN = 2000,
    parameter int TS_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_is_mem,
    input  logic              ret_is_store,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              in_ready,
    input  logic              cmd_collect_on,
    input  logic              cmd_collect_off,
    input  logic              cmd_sync,
    input  logic [TS_W-1:0]   sync_ts,
    output logic              dump_valid,
    input  logic              dump_ready,
    output logic [TS_W-1:0]   dump_ts,
    output logic [SIG_W-1:0]  dump_rd_sig,
    output logic [SIG_W-1:0]  dump_wr_sig,
    input  logic [SIG_W-1:0]  peer_rd_sig,
    input  logic [SIG_W-1:0]  peer_wr_sig,
    output logic              conflict,
    output logic              sig_empty
);
    logic [SIG_W-1:0] rd_q, wr_q, drd_q, dwr_q;
    logic [SIG_W-1:0] enc_bits, add_rd, add_wr, rd_next, wr_next;
    logic [TS_W-1:0]  ts_q, dts_q;
    logic             col_q, dv_q;
    logic             ret_fire, sync_fire, take, expire, dump_evt;

    h3_sig_encoder #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .NUM_SUB(NUM_SUB)) enc_i (
        .addr (ret_addr),
        .bits (enc_bits)
    );

    block_counter #(.BLOCK_LEN(BLOCK_LEN)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ret_fire),
        .clr    (dump_evt),
        .expire (expire)
    );

    sig_conflict_check #(.SIG_W(SIG_W)) chk_i (
        .rd_sig   (rd_q),
        .wr_sig   (wr_q),
        .peer_rd  (peer_rd_sig),
        .peer_wr  (peer_wr_sig),
        .conflict (conflict),
        .empty    (sig_empty)
    );

    // Acceptance and the next signature contents, including this cycle's access.
    always_comb begin
        in_ready  = !dv_q || dump_ready;
        ret_fire  = ret_valid && in_ready;
        sync_fire = cmd_sync && in_ready;
        take      = ret_fire && ret_is_mem && col_q;
        add_rd    = (take && !ret_is_store) ? enc_bits : '0;
        add_wr    = (take &&  ret_is_store) ? enc_bits : '0;
        rd_next   = rd_q | add_rd;
        wr_next   = wr_q | add_wr;
        dump_evt  = expire || sync_fire;
    end

    // Collection enable: off wins over on.
    always_ff @(posedge clk) begin
        if (!rst_n)               col_q <= 1'b0;
        else if (cmd_collect_off) col_q <= 1'b0;
        else if (cmd_collect_on)  col_q <= 1'b1;
    end

    // Live signatures and timestamp: accumulate, or clear on a dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
            ts_q <= '0;
        end else if (dump_evt) begin
            rd_q <= '0;
            wr_q <= '0;
            if (sync_fire) ts_q <= sync_ts;
        end else begin
            rd_q <= rd_next;
            wr_q <= wr_next;
        end
    end

    // Dump holding register: capture on an event, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q  <= 1'b0;
            dts_q <= '0;
            drd_q <= '0;
            dwr_q <= '0;
        end else if (dump_evt) begin
            dv_q  <= 1'b1;
            dts_q <= ts_q;
            drd_q <= rd_next;
            dwr_q <= wr_next;
        end else if (dump_ready) begin
            dv_q  <= 1'b0;
        end
    end

    assign dump_valid  = dv_q;
    assign dump_ts     = dts_q;
    assign dump_rd_sig = drd_q;
    assign dump_wr_sig = dwr_q;

    assert_hold_dump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dump_valid && !dump_ready |=> dump_valid && $stable(dump_ts)
            && $stable(dump_rd_sig) && $stable(dump_wr_sig));

    assert_clear_after_dump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dump_evt |=> rd_q == '0 && wr_q == '0);

    assert_disabled_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !col_q && !dump_evt |=> rd_q == $past(rd_q) && wr_q == $past(wr_q));

    assert_load_not_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_fire && ret_is_store) && !dump_evt |=> wr_q == $past(wr_q));

    assert_expiry_dumps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> dump_valid);

    assert_sync_ts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fire |=> ts_q == $past(sync_ts) && dump_ts == $past(ts_q));

    // Each collected access adds one bit per sub-filter at most (R2).
    assert_one_per_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $countones(enc_bits) == NUM_SUB);
endmodule

// File: tb/addr_sig_collector_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared each cycle against a bench-side model written from the requirements.
module addr_sig_collector_tb_top;
    localparam int ADDR_W = 16, SIG_W = 64, NUM_SUB = 4, BLOCK_LEN = 6, TS_W = 8;
    localparam int SUB_W = SIG_W / NUM_SUB;
    localparam int IDX_W = $clog2(SUB_W);

    logic clk = 0, rst_n = 0;
    logic ret_valid = 0, ret_is_mem = 0, ret_is_store = 0;
    logic [ADDR_W-1:0] ret_addr = '0;
    logic in_ready, cmd_collect_on = 0, cmd_collect_off = 0, cmd_sync = 0;
    logic [TS_W-1:0] sync_ts = '0, dump_ts;
    logic dump_valid, dump_ready = 1, conflict, sig_empty;
    logic [SIG_W-1:0] dump_rd_sig, dump_wr_sig, peer_rd_sig = '0, peer_wr_sig = '0;

    addr_sig_collector #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .NUM_SUB(NUM_SUB),
        .BLOCK_LEN(BLOCK_LEN), .TS_W(TS_W)) dut_i (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [SIG_W-1:0] m_rd, m_wr, m_drd, m_dwr;
    logic [TS_W-1:0]  m_ts, m_dts;
    logic m_col, m_dv;
    int   m_cnt;

    function automatic logic [SIG_W-1:0] ref_hash(input logic [ADDR_W-1:0] a);
        logic [SIG_W-1:0] v = '0;
        for (int s = 0; s < NUM_SUB; s++) begin
            int ix = 0;
            for (int b = 0; b < IDX_W; b++) begin
                int k = s * IDX_W + b;
                logic [31:0] m = (32'h9E3779B1 * 32'(k + 1)) ^ (32'h85EBCA6B >> (k % 32));
                if (^(a & m[ADDR_W-1:0])) ix = ix | (1 << b);
            end
            v[s*SUB_W + ix] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [SIG_W-1:0] act, input logic [SIG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle of stimulus; the model follows the requirements.
    task automatic step(input string tag, input logic rv, input logic mem, input logic st,
                        input logic [ADDR_W-1:0] a, input logic sy, input logic [TS_W-1:0] sts,
                        input logic con, input logic coff, input logic drdy);
        logic rdy, fire, sfire, evt;
        logic [SIG_W-1:0] nb, nrd, nwr;
        @(negedge clk);
        ret_valid = rv; ret_is_mem = mem; ret_is_store = st; ret_addr = a;
        cmd_sync = sy; sync_ts = sts; cmd_collect_on = con; cmd_collect_off = coff;
        dump_ready = drdy;
        #1;
        rdy = !m_dv || drdy;
        chk("R8 in_ready", SIG_W'(in_ready), SIG_W'(rdy));
        fire = rv && rdy; sfire = sy && rdy;
        nb = (fire && mem && m_col) ? ref_hash(a) : '0;
        nrd = m_rd | (st ? '0 : nb);
        nwr = m_wr | (st ? nb : '0);
        evt = ((m_cnt + int'(fire)) == BLOCK_LEN) || sfire;
        if (evt) begin
            m_dv = 1; m_dts = m_ts; m_drd = nrd; m_dwr = nwr;
            m_rd = '0; m_wr = '0; m_cnt = 0;
            if (sfire) m_ts = sts;
        end else begin
            if (drdy) m_dv = 0;
            m_rd = nrd; m_wr = nwr; m_cnt = m_cnt + int'(fire);
        end
        if (coff) m_col = 0; else if (con) m_col = 1;
        @(posedge clk); #2;
        chk({tag, " dump_valid"}, SIG_W'(dump_valid), SIG_W'(m_dv));
        if (m_dv) begin
            chk({tag, " dump_ts"}, SIG_W'(dump_ts), SIG_W'(m_dts));
            chk({tag, " dump_rd"}, dump_rd_sig, m_drd);
            chk({tag, " dump_wr"}, dump_wr_sig, m_dwr);
        end
        chk("R9 conflict", SIG_W'(conflict),
            SIG_W'((|(m_rd & peer_wr_sig)) | (|(m_wr & peer_wr_sig)) | (|(m_wr & peer_rd_sig))));
        chk("R9/R10 sig_empty", SIG_W'(sig_empty), SIG_W'(m_rd == '0 && m_wr == '0));
    endtask

    task automatic idle(input string tag, input logic drdy);
        step(tag, 0, 0, 0, '0, 0, '0, 0, 0, drdy);
    endtask

    initial begin
        int seed = 7;
        void'($urandom(seed));
        m_rd = '0; m_wr = '0; m_drd = '0; m_dwr = '0; m_ts = '0; m_dts = '0;
        m_col = 0; m_dv = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state seen at the ports.
        peer_rd_sig = '1; peer_wr_sig = '1;
        #1;
        chk("R1 dump_valid", SIG_W'(dump_valid), '0);
        chk("R1 sig_empty", SIG_W'(sig_empty), SIG_W'(1));
        chk("R1 conflict", SIG_W'(conflict), '0);
        // R1/R4: collection disabled after reset; loads leave signatures empty.
        step("R4", 1, 1, 0, 16'h1234, 0, '0, 0, 0, 1);
        // R5/R7: counter started at zero, expiry on the BLOCK_LEN-th retire.
        for (int i = 0; i < BLOCK_LEN - 2; i++) step("R5", 1, 0, 0, '0, 0, '0, 0, 0, 1);
        step("R5", 1, 0, 0, '0, 0, '0, 1, 0, 1);
        // R4: collection now on. Load then store: R2/R3 bit placement.
        step("R3", 1, 1, 0, 16'h00A5, 0, '0, 0, 0, 1);
        step("R3", 1, 1, 1, 16'hBEEF, 0, '0, 0, 0, 1);
        // R6: sync dumps old timestamp, includes in-cycle access, loads new ts.
        step("R6", 1, 1, 1, 16'h4321, 1, 8'h5A, 0, 0, 1);
        idle("R6", 1);
        // R7: sync in the same cycle as expiry gives one dump.
        for (int i = 0; i < BLOCK_LEN - 1; i++) step("R7", 1, 1, 0, 16'(i * 97), 0, '0, 0, 0, 1);
        step("R7", 1, 1, 1, 16'h0F0F, 1, 8'hC3, 0, 0, 1);
        idle("R7", 1);
        // R8: stall with dump_ready low; retire and sync ignored.
        step("R8", 1, 1, 0, 16'h7777, 1, 8'h11, 0, 0, 0);
        step("R8", 1, 1, 0, 16'h2222, 0, '0, 0, 0, 0);
        step("R8", 1, 1, 1, 16'h3333, 1, 8'h22, 0, 0, 0);
        idle("R8", 1);
        // R4: on and off together, off wins.
        step("R4", 0, 0, 0, '0, 0, '0, 1, 1, 1);
        step("R4", 1, 1, 1, 16'h9999, 0, '0, 0, 0, 1);
        step("R4", 0, 0, 0, '0, 0, '0, 1, 0, 1);
        // Seeded random traffic.
        for (int i = 0; i < 1500; i++) begin
            peer_rd_sig = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            peer_wr_sig = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            step("R5/R6", ($urandom % 10) < 7, ($urandom % 10) < 6, $urandom % 2,
                 16'($urandom), ($urandom % 12) == 0, 8'($urandom),
                 ($urandom % 10) == 0, ($urandom % 20) == 0, ($urandom % 10) < 7);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule